// File: doc/BRIEF.md
# Flash ECC Error Capture Registers

This block sits beside the bus port of an on-chip flash array and watches two things: the pipelined bus transfers that reach the array, and the single-cycle error pulses from the array's ECC decoder. It does not compute or correct ECC itself. When the decoder flags an error in a transfer's data phase and reporting for that kind of error is enabled, the block freezes a snapshot of the failing access. The snapshot holds the address, the requesting master, a packed attribute byte and the 32-bit data word. It also raises a sticky status flag for the error kind.

Because the bus is pipelined, the address-phase attributes of a transfer are copied into a holding stage when the address phase is accepted. They are used when the error arrives in the following data phase. Software reads the snapshot through a small byte-wide register port. The snapshot bytes ignore writes. The enable byte is read/write, and the status flags are cleared by writing ones.

Top module: `flash_ecc_capture`

## Requirements
- R1: On an enabled ECC event, the address, master, attribute and data capture registers are all loaded in the same clock edge from the same failing access.
- R2: An enabled correctable event sets status bit 0, and an enabled non-correctable event sets status bit 1. Both flags stay set until cleared.
- R3: The 32-bit data capture register holds the data word of the most recent enabled ECC event.
- R4: Register writes to any capture byte (offsets 0-5 and 8-11) leave that byte unchanged.
- R5: Attribute byte bit 7 holds the bus write signal of the captured access: 0 for a read, 1 for a write.
- R6: Attribute byte bits 6:4 hold the 3-bit transfer size: 000 is 8-bit, 001 is 16-bit, 010 is 32-bit and 1xx is reserved. The value is recorded as seen.
- R7: Attribute byte bits 3:0 hold bus protection bits prot[3:0] in the same order: cacheable, bufferable, privileged and data-not-fetch.
- R8: After reset, attribute bits 7:4, the enable byte, the status flags, the address, master and data captures all read zero. Attribute bits 3:0 are left unreset.
- R9: Enable byte bit 0 gates correctable reporting and bit 1 gates non-correctable reporting. An event of a disabled kind changes neither the captures nor the flags.
- R10: Writing a one to a status bit clears that flag. Writing a zero leaves it alone. A new event in the same cycle as a clear wins, and the flag stays set.
- R11: If enabled correctable and non-correctable events coincide, only the non-correctable flag is set by that event.
- R12: A capture uses the address-phase values of the transfer whose data phase carries the error, even when the next address phase is accepted in that same cycle.
- R13: The register map is little-endian by byte: offsets 0-3 are the address, 4 the master, 5 the attributes, 6 the enables, 7 the status and 8-11 the data. Other offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Address phase of a transfer to the flash is present |
| bus_ready | input | 1 | Current phase completes this cycle |
| bus_addr | input | ADDR_W | Address-phase address |
| bus_master | input | MST_W | Address-phase master number |
| bus_write | input | 1 | Address-phase write indicator |
| bus_size | input | 3 | Address-phase transfer size |
| bus_prot | input | 4 | Address-phase protection bits |
| bus_data | input | 32 | Data-phase data word |
| ecc_corr | input | 1 | Data-phase correctable error pulse |
| ecc_uncorr | input | 1 | Data-phase non-correctable error pulse |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |

## Verification
A wrong holding stage shows up as the attributes of the next transfer in the captured bytes. This appears at the first readback after an error that arrives while a new address phase is accepted. A broken enable or priority path shows as a flag or capture byte that differs from the model on the next register read after the event, which is one clock later. Random bus traffic with random register writes is compared byte by byte against a bench model every few cycles. This bounds how long any divergence can stay hidden.

// File: rtl/flash_ecc_capture.sv
module flash_ecc_capture #(
  parameter int ADDR_W = 32,
  parameter int MST_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [MST_W-1:0]  bus_master,
  input  logic              bus_write,
  input  logic [2:0]        bus_size,
  input  logic [3:0]        bus_prot,
  input  logic [31:0]       bus_data,
  input  logic              ecc_corr,
  input  logic              ecc_uncorr,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  localparam logic [3:0] OFS_MST  = 4'd4;
  localparam logic [3:0] OFS_ATTR = 4'd5;
  localparam logic [3:0] OFS_CFG  = 4'd6;
  localparam logic [3:0] OFS_STAT = 4'd7;

  logic [ADDR_W-1:0] hold_addr, cap_addr;
  logic [MST_W-1:0]  hold_mst, cap_mst;
  logic [7:0]        hold_attr;
  logic [3:0]        cap_hi;
  logic [3:0]        cap_prot;
  logic [31:0]       cap_data;
  logic [7:0]        cfg;
  logic [1:0]        flg;
  logic              dp_act;

  wire addr_take = bus_sel & bus_ready;
  wire dp_done   = dp_act & bus_ready;
  wire take_unc  = dp_done & ecc_uncorr & cfg[1];
  wire take_cor  = dp_done & ecc_corr & cfg[0];
  wire capture   = take_unc | take_cor;
  wire stat_wr   = reg_wr & (reg_addr == OFS_STAT);
  wire [1:0] flg_set = {take_unc, take_cor & ~take_unc};
  wire [1:0] flg_clr = stat_wr ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr <= '0;
      hold_mst  <= '0;
      hold_attr <= '0;
      dp_act    <= 1'b0;
    end else if (bus_ready) begin
      dp_act <= bus_sel;
      if (addr_take) begin
        hold_addr <= bus_addr;
        hold_mst  <= bus_master;
        hold_attr <= {bus_write, bus_size, bus_prot};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_mst  <= '0;
      cap_hi   <= '0;
      cap_data <= '0;
    end else if (capture) begin
      cap_addr <= hold_addr;
      cap_mst  <= hold_mst;
      cap_hi   <= hold_attr[7:4];
      cap_data <= bus_data;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) cap_prot <= hold_attr[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      flg <= '0;
    end else begin
      if (reg_wr && reg_addr == OFS_CFG) cfg <= reg_wdata;
      flg <= (flg & ~flg_clr) | flg_set;
    end
  end

  wire [31:0] addr32 = 32'(cap_addr);

  always_comb begin
    case (reg_addr)
      4'd0:     reg_rdata = addr32[7:0];
      4'd1:     reg_rdata = addr32[15:8];
      4'd2:     reg_rdata = addr32[23:16];
      4'd3:     reg_rdata = addr32[31:24];
      OFS_MST:  reg_rdata = 8'(cap_mst);
      OFS_ATTR: reg_rdata = {cap_hi, cap_prot};
      OFS_CFG:  reg_rdata = cfg;
      OFS_STAT: reg_rdata = {6'd0, flg};
      4'd8:     reg_rdata = cap_data[7:0];
      4'd9:     reg_rdata = cap_data[15:8];
      4'd10:    reg_rdata = cap_data[23:16];
      4'd11:    reg_rdata = cap_data[31:24];
      default:  reg_rdata = 8'd0;
    endcase
  end

  p_capture_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (cap_addr == $past(hold_addr)) && (cap_mst == $past(hold_mst))
                && (cap_data == $past(bus_data)));

  p_cor_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_act && bus_ready && ecc_corr && cfg[0] && !(ecc_uncorr && cfg[1])) |=> flg[0]);

  p_unc_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_act && bus_ready && ecc_uncorr && cfg[1]) |=> flg[1]);

  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(cap_addr) && $stable(cap_mst) && $stable(cap_hi) && $stable(cap_data));

  p_attr_pack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> cap_hi == $past(hold_attr[7:4]));

  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ecc_corr && cfg[0]) && !(ecc_uncorr && cfg[1]) && !stat_wr) |=> $stable(flg));

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[0] && !(dp_done && ecc_corr && cfg[0])) |=> !flg[0]);

  p_unc_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_unc && take_cor && !flg[0] && !stat_wr) |=> !flg[0]);

  p_pipe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_take && !capture) |=> (hold_addr == $past(bus_addr)) && $stable(cap_addr));
endmodule

// File: tb/sim_flash_ecc_capture.sv
`timescale 1ns/1ps
module sim_flash_ecc_capture;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_sel = 0, d_rdy = 1, d_w = 0, d_ec = 0, d_eu = 0, d_wr = 0;
  logic [31:0] d_addr = 0, d_data = 0;
  logic [3:0]  d_mst = 0, d_prot = 0, d_raddr = 0;
  logic [2:0]  d_size = 0;
  logic [7:0]  d_wdata = 0;
  logic [7:0]  rdata;

  always #2.5 clk = ~clk;

  flash_ecc_capture #(.ADDR_W(32), .MST_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(d_sel), .bus_ready(d_rdy),
    .bus_addr(d_addr), .bus_master(d_mst), .bus_write(d_w), .bus_size(d_size),
    .bus_prot(d_prot), .bus_data(d_data), .ecc_corr(d_ec), .ecc_uncorr(d_eu),
    .reg_addr(d_raddr), .reg_wr(d_wr), .reg_wdata(d_wdata), .reg_rdata(rdata));

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_addr, m_data, m_haddr;
  logic [3:0]  m_mst, m_hmst;
  logic [7:0]  m_attr, m_hattr, m_cfg;
  logic [1:0]  m_flg;
  logic        m_dp, m_pknown;

  function automatic logic [7:0] pack_attr(logic w, logic [2:0] s, logic [3:0] p);
    return {w, s, p};
  endfunction

  function automatic logic [7:0] exp_byte(int a);
    case (a)
      0: return m_addr[7:0];
      1: return m_addr[15:8];
      2: return m_addr[23:16];
      3: return m_addr[31:24];
      4: return {4'd0, m_mst};
      5: return m_attr;
      6: return m_cfg;
      7: return {6'd0, m_flg};
      8: return m_data[7:0];
      9: return m_data[15:8];
      10: return m_data[23:16];
      11: return m_data[31:24];
      default: return 8'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_addr = 0; m_data = 0; m_haddr = 0; m_mst = 0; m_hmst = 0;
    m_attr = 0; m_hattr = 0; m_cfg = 0; m_flg = 0; m_dp = 0; m_pknown = 0;
  endtask

  task automatic model_step();
    logic tu, tc;
    logic [1:0] clr;
    tu = m_dp && d_rdy && d_eu && m_cfg[1];
    tc = m_dp && d_rdy && d_ec && m_cfg[0];
    if (tu || tc) begin
      m_addr = m_haddr; m_mst = m_hmst; m_attr = m_hattr; m_data = d_data; m_pknown = 1;
    end
    clr = (d_wr && d_raddr == 4'd7) ? d_wdata[1:0] : 2'b00;
    m_flg = (m_flg & ~clr) | {tu, tc && !tu};
    if (d_wr && d_raddr == 4'd6) m_cfg = d_wdata;
    if (d_rdy) begin
      if (d_sel) begin
        m_haddr = d_addr; m_hmst = d_mst; m_hattr = pack_attr(d_w, d_size, d_prot);
      end
      m_dp = d_sel;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
  endtask

  task automatic chk(logic [7:0] got, logic [7:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic idle();
    d_sel = 0; d_rdy = 1; d_ec = 0; d_eu = 0; d_wr = 0;
  endtask

  task automatic readback(string tag);
    idle();
    for (int a = 0; a < 13; a++) begin
      logic [7:0] m;
      d_raddr = 4'(a);
      #0.1;
      m = (a == 5 && !m_pknown) ? 8'hF0 : 8'hFF;
      chk(rdata & m, exp_byte(a) & m, $sformatf("%s R13 offset %0d", tag, a));
    end
    tick();
  endtask

  task automatic reg_write(logic [3:0] a, logic [7:0] v);
    idle(); d_wr = 1; d_raddr = a; d_wdata = v; tick(); d_wr = 0;
  endtask

  task automatic addr_phase(logic [31:0] a, logic [3:0] m, logic w, logic [2:0] s, logic [3:0] p);
    d_sel = 1; d_rdy = 1; d_addr = a; d_mst = m; d_w = w; d_size = s; d_prot = p;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    readback("R8 reset");

    reg_write(4'd6, 8'h03);
    readback("R9 enables");

    // R12: error in data phase of A while address phase of B is accepted
    addr_phase(32'h1000_0040, 4'd3, 1'b0, 3'b010, 4'b1011); d_ec = 0; tick();
    addr_phase(32'h2000_0080, 4'd9, 1'b1, 3'b001, 4'b0100); d_ec = 1; d_data = 32'hCAFE_0001; tick();
    idle();
    chk({4'd0, m_mst}, 8'h03, "R12 master of first transfer");
    chk(m_attr, 8'h2B, "R12 R5 R6 R7 attribute model");
    readback("R1 R2 R3 R12");

    // R12 second: data phase of B carries non-correctable error
    addr_phase(32'h3000_0000, 4'd1, 1'b0, 3'b000, 4'b0001); d_eu = 1; d_data = 32'h0BAD_F00D; tick();
    readback("R2 R5 R6 R7");

    // R4: writes to capture bytes ignored
    for (int a = 0; a < 12; a++) if (a != 6 && a != 7) reg_write(4'(a), 8'(a * 37 + 5));
    readback("R4");

    // R10: write-one clear
    reg_write(4'd7, 8'h01);
    readback("R10 clear bit0");
    reg_write(4'd7, 8'h00);
    readback("R10 zero write");
    reg_write(4'd7, 8'h02);
    readback("R10 clear bit1");

    // R10: set beats clear
    addr_phase(32'h4444_0000, 4'd2, 1'b1, 3'b010, 4'b1111); tick();
    idle(); d_ec = 1; d_wr = 1; d_raddr = 4'd7; d_wdata = 8'h01; d_data = 32'h1234_5678; tick();
    readback("R10 set priority");
    reg_write(4'd7, 8'h03);

    // R11: both at once
    addr_phase(32'h5555_0004, 4'd7, 1'b0, 3'b100, 4'b0110); tick();
    idle(); d_ec = 1; d_eu = 1; d_data = 32'hAAAA_5555; tick();
    readback("R11");
    reg_write(4'd7, 8'h03);

    // R9: disabled kinds
    reg_write(4'd6, 8'h00);
    addr_phase(32'h6666_0000, 4'd5, 1'b1, 3'b001, 4'b1000); tick();
    idle(); d_ec = 1; d_eu = 1; d_data = 32'hDEAD_BEEF; tick();
    readback("R9 both disabled");
    reg_write(4'd6, 8'h01);
    addr_phase(32'h7777_0000, 4'd6, 1'b0, 3'b010, 4'b0010); tick();
    idle(); d_eu = 1; d_data = 32'h7777_7777; tick();
    readback("R9 uncorrectable disabled");
    reg_write(4'd6, 8'h02);
    addr_phase(32'h8888_0000, 4'd4, 1'b1, 3'b000, 4'b0011); tick();
    idle(); d_ec = 1; d_data = 32'h8888_8888; tick();
    readback("R9 correctable disabled");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      d_sel = ($urandom % 3) != 0;
      d_rdy = ($urandom % 4) != 0;
      d_addr = $urandom; d_mst = 4'($urandom); d_w = 1'($urandom);
      d_size = 3'($urandom); d_prot = 4'($urandom); d_data = $urandom;
      d_ec = ($urandom % 5) == 0; d_eu = ($urandom % 7) == 0;
      d_wr = ($urandom % 4) == 0; d_raddr = 4'($urandom); d_wdata = 8'($urandom);
      if (d_wr && d_raddr == 4'd6) d_wdata[1:0] = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      tick();
      if (i % 16 == 15) readback("R1 R2 R3 R4 R9 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule